// File: doc/BRIEF.md
# Card Clock and Power Controller

This block produces the serial clock for a memory-card bus from the adapter clock and steps the card bus through its power phases. Software-visible control fields arrive as plain inputs: a requested power phase, a clock enable, a divider value, a bypass select, a power-save enable and a flow-control enable. Status inputs tell it whether the card bus is idle, which direction the current transfer runs, and whether the transmit FIFO is empty or the receive FIFO is full.

From these it drives the card clock pin, a one-cycle strobe that the command and data state machines use as their clock enable, and a mask of output enables for the command and data lines. The clock stops cleanly, always in its low phase, whenever the bus is not powered, software turns it off, power saving applies to an idle bus, or flow control has to wait for the FIFO. Divider and bypass changes only take effect at a period boundary, so the card never sees a shortened high pulse.

Top module: `card_clk_ctrl`

## Requirements
- R1: The phase request encodes 2'b00 off, 2'b10 power-up, 2'b11 power-on, and treats 2'b01 as off. A power-on request seen in the off phase first moves to power-up. The power-on phase is entered only after PUP_CYCLES clock cycles in power-up, so bus_oe turns on at the (PUP_CYCLES+1)-th rising edge after the request is first sampled.
- R2: bus_oe is all zeros in the off and power-up phases and equals oe_req bit for bit in the power-on phase.
- R3: After reset, and in the off and power-up phases, card_clk stays low and clk_strobe stays low.
- R4: With bypass low, card_clk has a period of div_val+2 adapter cycles: high for floor((div_val+2)/2) cycles and low for the rest.
- R5: With bypass high, card_clk is the adapter clock gated cleanly, rising on every adapter cycle while running.
- R6: clk_strobe is high for one adapter cycle ahead of each card_clk rising edge, and only then: the card clock rises at the adapter edge that ends the strobe cycle.
- R7: With pwrsave_en high and bus_idle high, the card clock stops. With bus_idle low it runs at its normal rate even when pwrsave_en is high.
- R8: With flowctl_en high, the clock and the strobe stop while dir_send=1 and tx_empty=1, or while dir_send=0 and rx_full=1. The other FIFO flag has no effect in each direction. With flowctl_en low, neither flag stops the clock.
- R9: A new div_val or bypass value is taken only at a period boundary while card_clk is low. Every high pulse therefore has the full length of either the old setting or the new one.
- R10: With clk_en low, the card clock and the strobe stop.
- R11: When any stop condition arises, a high phase already under way runs to its full length. The clock then rests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_req | input | 2 | Requested power phase |
| clk_en | input | 1 | Card clock enable |
| div_val | input | DIV_W | Divider value; period is div_val+2 |
| bypass | input | 1 | Pass the adapter clock straight through |
| pwrsave_en | input | 1 | Stop the clock while the bus is idle |
| flowctl_en | input | 1 | Stall the clock on FIFO empty/full |
| bus_idle | input | 1 | Card bus has no command or data activity |
| dir_send | input | 1 | 1 = transfer to card, 0 = from card |
| tx_empty | input | 1 | Transmit FIFO has no data |
| rx_full | input | 1 | Receive FIFO has no room |
| oe_req | input | BUS_W | Output enables wanted by the command and data paths |
| card_clk | output | 1 | Serial card clock |
| clk_strobe | output | 1 | One-cycle enable ahead of each card clock rising edge |
| bus_oe | output | BUS_W | Output enables after power-phase gating |

## Verification
The assertions rely on all control and status inputs changing only just after a rising adapter clock edge and staying steady until the next one. The bypass gate is loaded on the falling edge and must see settled values. They also rely on phase_req carrying one of its four codes without glitches. The stimulus changes every input two nanoseconds after a rising edge. It samples the card clock at fixed points in the high and low halves of each adapter cycle, which keeps every input change well away from both clock edges.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // Power phase of the card bus; the codes match the request field.
  typedef enum logic [1:0] {
    PH_OFF = 2'b00,
    PH_UP  = 2'b10,
    PH_ON  = 2'b11
  } pwr_ph_e;

  localparam logic [1:0] REQ_UP = 2'b10;
  localparam logic [1:0] REQ_ON = 2'b11;

endpackage

// File: rtl/cardclk_pwr_seq.sv
module cardclk_pwr_seq
  import cardclk_pkg::*;
#(
  parameter int PUP_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_req,
  output pwr_ph_e    state_o
);

  localparam int CW = (PUP_CYCLES > 1) ? $clog2(PUP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PUP_CYCLES - 1);

  pwr_ph_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          settled;
  logic          want_pwr;

  always_comb begin
    settled  = (cnt_q == LAST);
    want_pwr = (phase_req == REQ_UP) || (phase_req == REQ_ON);
    st_d     = st_q;
    unique case (st_q)
      PH_OFF: if (want_pwr) st_d = PH_UP;
      PH_UP: begin
        if (!want_pwr)                            st_d = PH_OFF;
        else if (phase_req == REQ_ON && settled)  st_d = PH_ON;
      end
      PH_ON: begin
        if (phase_req == REQ_UP)      st_d = PH_UP;
        else if (phase_req != REQ_ON) st_d = PH_OFF;
      end
      default: st_d = PH_OFF;
    endcase
    if (st_q == PH_UP) cnt_d = settled ? cnt_q : cnt_q + 1'b1;
    else               cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

  // R1: power-on is only ever entered from a settled power-up phase
  p_on_via_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_ON && $past(st_q) != PH_ON) |-> ($past(st_q) == PH_UP && $past(settled)));

  // R1: the off phase never jumps straight to power-on
  p_off_not_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == PH_OFF) |-> (st_q != PH_ON));

endmodule

// File: rtl/cardclk_gate.sv
module cardclk_gate (
  input  logic powered,
  input  logic clk_en,
  input  logic pwrsave_en,
  input  logic bus_idle,
  input  logic flowctl_en,
  input  logic dir_send,
  input  logic tx_empty,
  input  logic rx_full,
  output logic run
);

  logic starve;
  logic stall;
  logic doze;

  always_comb begin
    starve = dir_send ? tx_empty : rx_full;
    stall  = flowctl_en && starve;
    doze   = pwrsave_en && bus_idle;
    run    = powered && clk_en && !doze && !stall;
  end

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  output logic             card_clk,
  output logic             strobe
);

  localparam int NW = DIV_W + 2;

  logic [DIV_W-1:0] div_q, div_d;
  logic             byp_q, byp_d;
  logic [NW-1:0]    cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             gate_n, gate_d;
  logic [NW-1:0]    n_cur, n_nxt, hi_len, cnt_inc;
  logic             wrap, ld_div_mode, ld_byp, ld_div;

  always_comb begin
    n_cur       = NW'(div_q) + NW'(2);
    hi_len      = n_cur >> 1;
    wrap        = (cnt_q >= n_cur - NW'(1));
    cnt_inc     = cnt_q + NW'(1);
    gate_d      = run && byp_q && bypass;
    ld_div_mode = !byp_q && !clk_q && wrap;
    ld_byp      = byp_q ? !gate_n : ld_div_mode;
    ld_div      = byp_q || ld_div_mode;
    byp_d       = ld_byp ? bypass : byp_q;
    div_d       = ld_div ? div_val : div_q;
    n_nxt       = NW'(div_d) + NW'(2);
    cnt_d       = cnt_q;
    clk_d       = clk_q;
    if (byp_d) begin
      clk_d = 1'b0;
    end else if (byp_q) begin
      cnt_d = n_nxt - NW'(1);
      clk_d = 1'b0;
    end else if (clk_q) begin
      cnt_d = cnt_inc;
      clk_d = (cnt_inc < hi_len);
    end else if (wrap) begin
      if (run) begin
        cnt_d = '0;
        clk_d = 1'b1;
      end else begin
        cnt_d = n_nxt - NW'(1);
        clk_d = 1'b0;
      end
    end else begin
      cnt_d = cnt_inc;
      clk_d = 1'b0;
    end
    strobe = byp_q ? gate_d : (run && !clk_q && wrap && !bypass);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      byp_q <= 1'b0;
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      div_q <= div_d;
      byp_q <= byp_d;
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  // Bypass gate opens and closes only while the adapter clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= gate_d;
  end

  assign card_clk = byp_q ? (clk & gate_n) : clk_q;

  // R6: a divided-mode strobe is followed by a rising card clock
  p_strobe_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !byp_q) |=> clk_q);

  // R9: divider value is replaced only while the divided clock was low
  p_div_change_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q) && !$past(byp_q)) |-> !$past(clk_q));

  // R9: leaving bypass only after the gate has closed
  p_byp_exit_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byp_q) && !byp_q) |-> !$past(gate_n));

  // R11: a stopped divided clock at its boundary stays low
  p_stop_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp_q && !run && !clk_q && wrap) |=> !clk_q);

endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import cardclk_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int BUS_W      = 9,
  parameter int PUP_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase_req,
  input  logic             clk_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             bypass,
  input  logic             pwrsave_en,
  input  logic             flowctl_en,
  input  logic             bus_idle,
  input  logic             dir_send,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic [BUS_W-1:0] oe_req,
  output logic             card_clk,
  output logic             clk_strobe,
  output logic [BUS_W-1:0] bus_oe
);

  logic [1:0] rs_q;
  logic       rst_ni;
  pwr_ph_e    phase;
  logic       powered;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  cardclk_pwr_seq #(.PUP_CYCLES(PUP_CYCLES)) u_pwr (
    .clk       (clk),
    .rst_n     (rst_ni),
    .phase_req (phase_req),
    .state_o   (phase)
  );

  assign powered = (phase == PH_ON);

  cardclk_gate u_gate (
    .powered    (powered),
    .clk_en     (clk_en),
    .pwrsave_en (pwrsave_en),
    .bus_idle   (bus_idle),
    .flowctl_en (flowctl_en),
    .dir_send   (dir_send),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .run        (run)
  );

  cardclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run      (run),
    .div_val  (div_val),
    .bypass   (bypass),
    .card_clk (card_clk),
    .strobe   (clk_strobe)
  );

  for (genvar i = 0; i < BUS_W; i++) begin : g_oe
    assign bus_oe[i] = oe_req[i] & powered;
  end

  // R3: no strobe leaves the block unless the bus is in power-on
  p_quiet_unpowered_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase != PH_ON) |-> !clk_strobe);

  // R10: with the clock disabled no strobe is produced
  p_no_strobe_disabled_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!clk_en) |-> !clk_strobe);

endmodule

// File: tb/tb_card_clk_ctrl.sv
module tb_card_clk_ctrl;

  localparam int BUS_W = 9;
  localparam int PUP   = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       phase_req;
  logic             clk_en, bypass, pwrsave_en, flowctl_en;
  logic             bus_idle, dir_send, tx_empty, rx_full;
  logic [7:0]       div_val;
  logic [BUS_W-1:0] oe_req;
  logic             card_clk, clk_strobe;
  logic [BUS_W-1:0] bus_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  int rises, highs, strobes, smis, npl;
  int plens[64];

  always #10 clk = ~clk;

  card_clk_ctrl #(.DIV_W(8), .BUS_W(BUS_W), .PUP_CYCLES(PUP)) dut (
    .clk(clk), .rst_n(rst_n), .phase_req(phase_req), .clk_en(clk_en),
    .div_val(div_val), .bypass(bypass), .pwrsave_en(pwrsave_en),
    .flowctl_en(flowctl_en), .bus_idle(bus_idle), .dir_send(dir_send),
    .tx_empty(tx_empty), .rx_full(rx_full), .oe_req(oe_req),
    .card_clk(card_clk), .clk_strobe(clk_strobe), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Samples card_clk in the high and low half of each adapter cycle.
  // kind 1: change div_val at cycle chg_at; kind 2: drop clk_en there.
  task automatic measure(input int n, input int kind, input int chg_at, input int val);
    logic prev_lo, prev_st, hi, st, r;
    bit   have_prev, skip;
    int   hrun;
    rises = 0; highs = 0; strobes = 0; smis = 0; npl = 0;
    have_prev = 0; skip = 0; hrun = 0; prev_lo = 0; prev_st = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
      if (k == chg_at && kind == 1) div_val = val[7:0];
      if (k == chg_at && kind == 2) clk_en = 1'b0;
      #3;
      hi = card_clk;
      st = clk_strobe;
      if (k == 0 && hi) skip = 1;
      if (have_prev) begin
        r = !prev_lo && hi;
        if (r) rises++;
        if (prev_st) strobes++;
        if (prev_st != r) smis++;
        if (hi) highs++;
      end
      if (hi) hrun++;
      else if (hrun > 0) begin
        if (!skip && npl < 64) begin
          plens[npl] = hrun;
          npl++;
        end
        skip = 0;
        hrun = 0;
      end
      @(negedge clk);
      #5;
      prev_lo = card_clk;
      prev_st = st;
      have_prev = 1;
    end
  endtask

  task automatic t_reset();
    measure(10, 0, 0, 0);
    chk(highs == 0, "R3 reset card_clk highs", highs, 0);
    chk(strobes == 0, "R3 reset strobes", strobes, 0);
    chk(bus_oe == '0, "R2 reset bus_oe", int'(bus_oe), 0);
  endtask

  task automatic t_power_seq();
    step();
    phase_req = 2'b11;
    repeat (PUP) @(posedge clk);
    #5;
    chk(bus_oe == '0, "R1 still powering up", int'(bus_oe), 0);
    @(posedge clk);
    #5;
    chk(bus_oe == oe_req, "R1 power-on after settle", int'(bus_oe), int'(oe_req));
    step();
    oe_req = 9'h05A;
    #3;
    chk(bus_oe == oe_req, "R2 oe follows request", int'(bus_oe), int'(oe_req));
  endtask

  task automatic t_divide(input int d);
    int nn;
    nn = d + 2;
    step();
    div_val = d[7:0];
    measure(2 * nn + 4, 0, 0, 0);
    measure(10 * nn + 1, 0, 0, 0);
    chk(rises == 10, "R4 rising edges per 10 periods", rises, 10);
    chk(highs == 10 * (nn / 2), "R4 high cycles", highs, 10 * (nn / 2));
    chk(strobes == 10, "R6 strobe count", strobes, 10);
    chk(smis == 0, "R6 strobe aligned to rise", smis, 0);
  endtask

  task automatic t_bypass();
    step();
    bypass = 1'b1;
    measure(12, 0, 0, 0);
    measure(21, 0, 0, 0);
    chk(rises == 20, "R5 bypass rises", rises, 20);
    chk(highs == 20, "R5 bypass highs", highs, 20);
    chk(smis == 0 && strobes == 20, "R5 bypass strobe each cycle", strobes, 20);
    step();
    bypass = 1'b0;
    div_val = 8'd3;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10 && smis == 0, "R9 back from bypass", rises, 10);
  endtask

  task automatic t_pwrsave();
    step();
    pwrsave_en = 1'b1;
    bus_idle = 1'b1;
    measure(12, 0, 0, 0);
    measure(21, 0, 0, 0);
    chk(rises == 0 && highs == 0, "R7 idle bus stops clock", highs, 0);
    chk(strobes == 0, "R7 idle bus no strobe", strobes, 0);
    step();
    bus_idle = 1'b0;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10, "R7 busy bus runs", rises, 10);
    step();
    pwrsave_en = 1'b0;
    bus_idle = 1'b1;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10, "R7 idle without power save runs", rises, 10);
    step();
    bus_idle = 1'b0;
  endtask

  task automatic t_flow();
    step();
    flowctl_en = 1'b1;
    dir_send = 1'b1;
    tx_empty = 1'b1;
    rx_full = 1'b0;
    measure(12, 0, 0, 0);
    measure(21, 0, 0, 0);
    chk(rises == 0 && strobes == 0, "R8 send stalls on empty tx", rises, 0);
    step();
    tx_empty = 1'b0;
    rx_full = 1'b1;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10, "R8 send ignores rx full", rises, 10);
    step();
    dir_send = 1'b0;
    measure(12, 0, 0, 0);
    measure(21, 0, 0, 0);
    chk(rises == 0 && strobes == 0, "R8 receive stalls on full rx", rises, 0);
    step();
    flowctl_en = 1'b0;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10, "R8 flow control off runs", rises, 10);
    step();
    rx_full = 1'b0;
  endtask

  task automatic t_change_div();
    bit ok;
    measure(80, 1, 13, 6);
    ok = (npl >= 3);
    for (int i = 0; i < npl; i++)
      if (plens[i] != 2 && plens[i] != 4) ok = 0;
    chk(ok, "R9 high pulses full length", npl, 3);
    chk(smis == 0, "R9 strobe stays aligned", smis, 0);
    step();
    div_val = 8'd3;
    measure(12, 0, 0, 0);
  endtask

  task automatic t_stop_enable();
    bit ok;
    measure(41, 2, 7, 0);
    ok = (npl >= 1);
    for (int i = 0; i < npl; i++)
      if (plens[i] != 2) ok = 0;
    chk(ok, "R11 last high pulse complete", npl, 1);
    measure(21, 0, 0, 0);
    chk(highs == 0 && strobes == 0, "R10 disabled clock rests low", highs, 0);
    step();
    clk_en = 1'b1;
    measure(12, 0, 0, 0);
  endtask

  task automatic t_power_off();
    step();
    phase_req = 2'b01;
    measure(12, 0, 0, 0);
    measure(21, 0, 0, 0);
    chk(highs == 0 && strobes == 0, "R3 off phase clock low", highs, 0);
    chk(bus_oe == '0, "R2 off phase oe", int'(bus_oe), 0);
    step();
    phase_req = 2'b10;
    measure(41, 0, 0, 0);
    chk(highs == 0 && strobes == 0, "R3 power-up clock low", highs, 0);
    chk(bus_oe == '0, "R2 power-up oe", int'(bus_oe), 0);
    step();
    phase_req = 2'b11;
    measure(12, 0, 0, 0);
    measure(51, 0, 0, 0);
    chk(rises == 10, "R1 power-on from settled power-up", rises, 10);
    chk(bus_oe == oe_req, "R2 power-on oe", int'(bus_oe), int'(oe_req));
  endtask

  initial begin
    rst_n = 1'b0;
    phase_req = 2'b00; clk_en = 1'b1; div_val = 8'd3; bypass = 1'b0;
    pwrsave_en = 1'b0; flowctl_en = 1'b0; bus_idle = 1'b0; dir_send = 1'b1;
    tx_empty = 1'b0; rx_full = 1'b0; oe_req = 9'h1A5;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_power_seq();
    t_divide(3);
    t_divide(0);
    t_divide(6);
    t_divide(3);
    t_bypass();
    t_pwrsave();
    t_flow();
    t_change_div();
    t_stop_enable();
    t_power_off();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule